// File: doc/BRIEF.md
# Packed Day/Hour/Minute/Second Counter

This block keeps wall-clock time as a single 32-bit packed word holding a day count together with the hour, minute and second of that day. It runs from a 32.768 kHz clock. A built-in divider turns that clock into a once-per-second advance. The divider can be bypassed so the count steps on every clock, which helps bring-up and fast test. Each field wraps at its own radix and carries into the next field up. The day field is a plain 15-bit binary count.

On every advance the block gives a one-cycle pulse for the second. It also gives one-cycle pulses for minute, hour and day rollovers. The advanced value is compared against an alarm word in one of two modes. In time-of-day mode the days are ignored, so the alarm repeats every 24 hours. In full mode every field, the day included, must match. Software-side logic can overwrite the whole word at any time. An overwrite also restarts the divider, so the first advance after it comes one full second later.

Top module: `tod_counter`

## Requirements
- R1: While reset is asserted and right after it, `count_word` is zero and all five pulse outputs are low.
- R2: The word is packed as seconds in bits 5:0, minutes in bits 11:6, hours in bits 16:12 and days in bits 31:17. A load places `load_word` unchanged into `count_word` on the next cycle.
- R3: With `prescale_en` high, the count advances once every `PRESCALE_DIV` cycles (32768 by default). A load restarts the divider phase, so the first advance after a load appears `PRESCALE_DIV` cycles after the load cycle.
- R4: With `prescale_en` low and no load, the count advances on every clock cycle.
- R5: Seconds count 0 to 59 and then wrap to 0, which increments minutes. Minutes wrap from 59 to 0, which increments hours. Hours wrap from 23 to 0, which increments days.
- R6: Days wrap from 0x7FFF to 0 with no effect on any other field.
- R7: `sec_pulse` is high for exactly the cycle in which each advanced value first appears. `min_pulse`, `hour_pulse` and `day_pulse` are high in that same cycle when the seconds, minutes or hours field respectively has just wrapped.
- R8: With `alarm_full` low, `alarm_pulse` fires when the seconds, minutes and hours of the advanced value equal bits 16:0 of `alarm_word`. The day field is ignored.
- R9: With `alarm_full` high, `alarm_pulse` fires only when all 32 bits of the advanced value equal `alarm_word`.
- R10: `alarm_pulse` lasts one cycle and is produced only by an advance, never by a load of a matching value.
- R11: A load takes priority over an advance in the same cycle, and no pulse output is raised for a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz timebase clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prescale_en | input | 1 | High: advance once per `PRESCALE_DIV` cycles; low: every cycle |
| load_en | input | 1 | Overwrite the count with `load_word` |
| load_word | input | 32 | Packed value to load |
| alarm_word | input | 32 | Packed alarm compare value |
| alarm_full | input | 1 | High: compare all fields; low: ignore days |
| count_word | output | 32 | Current packed count |
| sec_pulse | output | 1 | One-cycle pulse on every advance |
| min_pulse | output | 1 | Seconds wrapped on this advance |
| hour_pulse | output | 1 | Minutes wrapped on this advance |
| day_pulse | output | 1 | Hours wrapped on this advance |
| alarm_pulse | output | 1 | Advanced value matched the alarm |

## Verification
The range assertions on the time fields assume that every loaded word has seconds and minutes no larger than 59 and hours no larger than 23. An out-of-range field is outside the defined behaviour, so the stimulus only loads legal words. The checks on divider spacing assume a `PRESCALE_DIV` of at least two. The bench therefore keeps the default divider and reaches the boundary values by loading words near each rollover, not by counting up to them.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int SEC_W     = 6;
  localparam int MIN_W     = 6;
  localparam int HOUR_W    = 5;
  localparam int DAY_W     = 15;
  localparam int SEC_LAST  = 59;
  localparam int MIN_LAST  = 59;
  localparam int HOUR_LAST = 23;
  localparam int DAY_LAST  = (1 << DAY_W) - 1;
  localparam int TOD_W     = SEC_W + MIN_W + HOUR_W + DAY_W;
  localparam int TIME_W    = SEC_W + MIN_W + HOUR_W;

  typedef struct packed {
    logic [DAY_W-1:0]  day;
    logic [HOUR_W-1:0] hour;
    logic [MIN_W-1:0]  minute;
    logic [SEC_W-1:0]  sec;
  } tod_t;
endpackage

// File: rtl/tod_prescaler.sv
module tod_prescaler #(
  parameter int DIV = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic restart,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST_V = PW'(DIV - 1);

  logic [PW-1:0] phase_q, phase_d;

  always_comb begin
    tick = !enable || (phase_q == LAST_V);
    if (restart || !enable || (phase_q == LAST_V)) begin
      phase_d = '0;
    end else begin
      phase_d = phase_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_d;
    end
  end

  // R3: a divided tick is never followed by another on the next cycle
  a_r3_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && tick) |=> (!enable || !tick));
  // R3: a restart leaves at least one cycle without a divided tick
  a_r3_restart_gap: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!enable || !tick));
endmodule

// File: rtl/tod_field.sv
module tod_field #(
  parameter int W    = 6,
  parameter int LAST = 59
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  input  logic         step,
  output logic [W-1:0] value,
  output logic [W-1:0] nxt,
  output logic         carry
);
  localparam logic [W-1:0] LAST_V = W'(LAST);

  always_comb begin
    carry = step && (value == LAST_V);
    nxt   = value;
    if (load_en) begin
      nxt = load_val;
    end else if (step) begin
      nxt = carry ? '0 : value + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value <= '0;
    end else begin
      value <= nxt;
    end
  end

  // R5: a field changes only on a load or a step
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && !step) |=> $stable(value));
  // R5: a field never leaves its range given legal loads
  a_r5_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    value <= LAST_V);
  // R5: a carry out returns the field to zero
  a_r5_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (carry && !load_en) |=> (value == '0));
endmodule

// File: rtl/tod_alarm.sv
module tod_alarm
  import tod_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  tod_t cand,
  input  tod_t ref_word,
  input  logic full_mode,
  output logic hit
);
  logic time_eq, day_eq, match, hit_d;

  always_comb begin
    time_eq = (cand.sec == ref_word.sec) && (cand.minute == ref_word.minute)
           && (cand.hour == ref_word.hour);
    day_eq  = (cand.day == ref_word.day);
    match   = time_eq && (day_eq || !full_mode);
    hit_d   = step && match;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit <= 1'b0;
    end else begin
      hit <= hit_d;
    end
  end

  // R10: no compare hit without an advance in the cycle before
  a_r10_needs_step: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> !hit);
  // R9: full mode never hits on a day mismatch
  a_r9_day_needed: assert property (@(posedge clk) disable iff (!rst_n)
    (full_mode && (cand.day != ref_word.day)) |=> !hit);
endmodule

// File: rtl/tod_counter.sv
module tod_counter
  import tod_pkg::*;
#(
  parameter int PRESCALE_DIV = 32768
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prescale_en,
  input  logic              load_en,
  input  logic [TOD_W-1:0]  load_word,
  input  logic [TOD_W-1:0]  alarm_word,
  input  logic              alarm_full,
  output logic [TOD_W-1:0]  count_word,
  output logic              sec_pulse,
  output logic              min_pulse,
  output logic              hour_pulse,
  output logic              day_pulse,
  output logic              alarm_pulse
);
  tod_t ld, cur, nxt, alm;
  logic tick, step_s;
  logic c_sec, c_min, c_hour, c_day;
  logic [3:0] pulse_d, pulse_q;

  assign ld  = tod_t'(load_word);
  assign alm = tod_t'(alarm_word);

  tod_prescaler #(.DIV(PRESCALE_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .enable(prescale_en), .restart(load_en), .tick(tick)
  );

  assign step_s = tick && !load_en;

  tod_field #(.W(SEC_W), .LAST(SEC_LAST)) u_sec (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_val(ld.sec),
    .step(step_s), .value(cur.sec), .nxt(nxt.sec), .carry(c_sec)
  );
  tod_field #(.W(MIN_W), .LAST(MIN_LAST)) u_min (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_val(ld.minute),
    .step(c_sec), .value(cur.minute), .nxt(nxt.minute), .carry(c_min)
  );
  tod_field #(.W(HOUR_W), .LAST(HOUR_LAST)) u_hour (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_val(ld.hour),
    .step(c_min), .value(cur.hour), .nxt(nxt.hour), .carry(c_hour)
  );
  tod_field #(.W(DAY_W), .LAST(DAY_LAST)) u_day (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_val(ld.day),
    .step(c_hour), .value(cur.day), .nxt(nxt.day), .carry(c_day)
  );

  tod_alarm u_alarm (
    .clk(clk), .rst_n(rst_n), .step(step_s), .cand(nxt), .ref_word(alm),
    .full_mode(alarm_full), .hit(alarm_pulse)
  );

  always_comb begin
    pulse_d = {c_hour, c_min, c_sec, step_s};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= '0;
    end else begin
      pulse_q <= pulse_d;
    end
  end

  assign count_word = cur;
  assign sec_pulse  = pulse_q[0];
  assign min_pulse  = pulse_q[1];
  assign hour_pulse = pulse_q[2];
  assign day_pulse  = pulse_q[3];

  // R4: undivided mode advances every cycle
  a_r4_every_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (!prescale_en && !load_en) |=> sec_pulse);
  // R11: a load wins and raises no pulse
  a_r11_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (!sec_pulse && !alarm_pulse && count_word == $past(load_word)));
  // R7: rollover pulses nest inside one another
  a_r7_min_in_sec: assert property (@(posedge clk) disable iff (!rst_n)
    min_pulse |-> sec_pulse);
  a_r7_hour_in_min: assert property (@(posedge clk) disable iff (!rst_n)
    hour_pulse |-> min_pulse);
  a_r7_day_in_hour: assert property (@(posedge clk) disable iff (!rst_n)
    day_pulse |-> hour_pulse);
  // R10: alarm only coincides with an advance
  a_r10_alarm_on_sec: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_pulse |-> sec_pulse);
  // R6: the day wrap lands on an all-zero word
  a_r6_day_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    c_day |=> (count_word == '0));
endmodule

// File: tb/tod_counter_bench.sv
module tod_counter_bench;
  localparam int PERIOD = 10;
  localparam int DIV    = 32768;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        prescale_en, load_en, alarm_full;
  logic [31:0] load_word, alarm_word, count_word;
  logic        sec_pulse, min_pulse, hour_pulse, day_pulse, alarm_pulse;

  tod_counter u_tod_counter (
    .clk(clk), .rst_n(rst_n), .prescale_en(prescale_en), .load_en(load_en),
    .load_word(load_word), .alarm_word(alarm_word), .alarm_full(alarm_full),
    .count_word(count_word), .sec_pulse(sec_pulse), .min_pulse(min_pulse),
    .hour_pulse(hour_pulse), .day_pulse(day_pulse), .alarm_pulse(alarm_pulse)
  );

  always #(PERIOD/2) clk = ~clk;

  int total = 0;
  int bad   = 0;
  logic [31:0] q_cnt[$];
  logic [4:0]  q_pul[$];
  string       q_req[$];

  // model state and configuration
  int     m_s, m_m, m_h, m_d, m_ph;
  bit     c_pen, c_full;
  logic [31:0] c_alarm;
  string  cur_req;

  function automatic logic [31:0] pack(int d, int h, int mi, int s);
    return {d[14:0], h[4:0], mi[5:0], s[5:0]};
  endfunction

  task automatic check(string req, logic [31:0] got_c, logic [31:0] exp_c,
                       logic [4:0] got_p, logic [4:0] exp_p);
    total++;
    if (got_c !== exp_c || got_p !== exp_p) begin
      bad++;
      $display("FAIL %s: count=%h pulses=%b expected count=%h pulses=%b",
               req, got_c, got_p, exp_c, exp_p);
    end
  endtask

  task automatic set_cfg(bit pen, bit full, logic [31:0] aw);
    c_pen = pen; c_full = full; c_alarm = aw;
  endtask

  // driver: applies one cycle of stimulus and pushes the expected result
  task automatic cyc(bit ld, logic [31:0] w);
    logic [4:0] p;
    bit adv;
    logic [31:0] nw;
    @(negedge clk);
    prescale_en = c_pen; alarm_full = c_full; alarm_word = c_alarm;
    load_en = ld; load_word = w;
    p = '0;
    if (ld) begin
      m_s = w[5:0]; m_m = w[11:6]; m_h = w[16:12]; m_d = w[31:17]; m_ph = 0;
    end else begin
      adv  = c_pen ? (m_ph == DIV - 1) : 1'b1;
      m_ph = (c_pen && !adv) ? m_ph + 1 : 0;
      if (adv) begin
        p[0] = 1'b1;
        m_s++;
        if (m_s == 60) begin
          m_s = 0; p[1] = 1'b1; m_m++;
          if (m_m == 60) begin
            m_m = 0; p[2] = 1'b1; m_h++;
            if (m_h == 24) begin
              m_h = 0; p[3] = 1'b1; m_d = (m_d + 1) % 32768;
            end
          end
        end
        nw = pack(m_d, m_h, m_m, m_s);
        p[4] = c_full ? (nw == c_alarm) : (nw[16:0] == c_alarm[16:0]);
      end
    end
    q_cnt.push_back(pack(m_d, m_h, m_m, m_s));
    q_pul.push_back(p);
    q_req.push_back(cur_req);
  endtask

  // monitor: pops one expected item per clock edge
  always @(posedge clk) begin
    #1;
    if (q_cnt.size() > 0) begin
      check(q_req.pop_front(), count_word, q_cnt.pop_front(),
            {alarm_pulse, day_pulse, hour_pulse, min_pulse, sec_pulse},
            q_pul.pop_front());
    end
  end

  initial begin
    #(PERIOD * 200000);
    bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; prescale_en = 1'b0; load_en = 1'b0; alarm_full = 1'b0;
    load_word = '0; alarm_word = 32'hFFFF_FFFF;
    set_cfg(1'b0, 1'b0, 32'hFFFF_FFFF);
    m_s = 0; m_m = 0; m_h = 0; m_d = 0; m_ph = 0;
    #(PERIOD * 3);
    check("R1 reset", count_word, '0,
          {alarm_pulse, day_pulse, hour_pulse, min_pulse, sec_pulse}, '0);
    @(negedge clk); rst_n = 1'b1;

    // R2 packing and R11 load without pulses
    cur_req = "R2/R11 load";
    cyc(1, pack(5, 23, 59, 58));
    cur_req = "R4/R5/R7 rollover chain";
    for (int i = 0; i < 4; i++) cyc(0, '0);

    cur_req = "R5 minute carry";
    cyc(1, pack(0, 3, 14, 58));
    for (int i = 0; i < 3; i++) cyc(0, '0);

    cur_req = "R6 day wrap";
    cyc(1, pack(32767, 23, 59, 57));
    for (int i = 0; i < 4; i++) cyc(0, '0);

    // R8 time-of-day alarm ignores days
    set_cfg(1'b0, 1'b0, pack(9, 0, 0, 3));
    cur_req = "R8 time-of-day alarm";
    cyc(1, pack(2, 0, 0, 0));
    for (int i = 0; i < 5; i++) cyc(0, '0);

    // R9 full alarm: day mismatch then match
    set_cfg(1'b0, 1'b1, pack(9, 0, 0, 3));
    cur_req = "R9 full alarm miss";
    cyc(1, pack(2, 0, 0, 0));
    for (int i = 0; i < 5; i++) cyc(0, '0);
    cur_req = "R9 full alarm hit";
    cyc(1, pack(9, 0, 0, 0));
    for (int i = 0; i < 5; i++) cyc(0, '0);

    // R10 loading the alarm value raises no alarm
    cur_req = "R10 load of matching word";
    cyc(1, pack(9, 0, 0, 3));
    cyc(1, pack(9, 0, 0, 3));
    cyc(0, '0);

    // R11 back-to-back loads while running
    set_cfg(1'b0, 1'b0, 32'hFFFF_FFFF);
    cur_req = "R11 load priority";
    cyc(0, '0);
    cyc(1, pack(100, 12, 30, 0));
    cyc(1, pack(101, 1, 2, 3));
    cyc(0, '0);

    // R3 divided rate and phase restart on load
    set_cfg(1'b1, 1'b0, pack(0, 0, 0, 1));
    cur_req = "R3 divided advance";
    cyc(1, pack(0, 0, 0, 0));
    for (int i = 0; i < DIV + 4; i++) cyc(0, '0);
    cur_req = "R3 phase restart";
    for (int i = 0; i < 1000; i++) cyc(0, '0);
    cyc(1, pack(0, 0, 0, 59));
    for (int i = 0; i < DIV + 4; i++) cyc(0, '0);

    @(posedge clk); #2;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule